// File: doc/BRIEF.md
# Interrupt Destination Matcher

This block sits beside a group of N local interrupt controllers (eight by default) and decides which of them an interprocessor or routed interrupt command reaches. It takes a two-word command, the index of the unit that sent it, and the current addressing configuration of every unit. It returns, one clock later, the set of units that receive the interrupt. Each unit's configuration is a physical ID, an 8-bit logical destination and a 4-bit destination model.

Matching can be physical, with a broadcast value, or logical. Logical matching follows each unit's own model, which is either flat bitmask or cluster. A two-bit shorthand can override the destination field and select the sender alone, every unit, or every unit but the sender. For lowest-priority delivery the block names a single target, the lowest-indexed unit that matched. An INIT command with level clear and trigger set delivers nothing. Instead, each selected unit's arbitration ID is reloaded from its physical ID. The block keeps those arbitration IDs and shows them on a port.

Top module: `idm_matcher`

## Requirements
- R1: In physical mode (command low word bit 11 = 0) with shorthand 0, a destination (high word bits 31:24) of 0xFF selects every unit.
- R2: In physical mode with shorthand 0 and any other destination, exactly the units whose physical ID equals the destination are selected.
- R3: In logical mode (bit 11 = 1) with shorthand 0, a unit whose model is 0xF matches when the destination ANDed with its logical destination is nonzero.
- R4: In logical mode, a unit whose model is 0x0 matches when the upper nibbles of destination and logical destination are equal and the lower nibbles share a set bit.
- R5: In logical mode, a unit whose model is neither 0xF nor 0x0 never matches.
- R6: Shorthand (low word bits 19:18) code 1 selects only the unit numbered by `sender_idx`, whatever the destination.
- R7: Shorthand code 2 selects every unit, and code 3 selects every unit except the sender.
- R8: For delivery mode 1 (low word bits 10:8), `deliver_mask` holds only the lowest-indexed matched unit, `lp_hit` is 1 and `lp_index` is that unit's index. For every other mode, `lp_hit` is 0 and `lp_index` is 0.
- R9: When no unit matches, `deliver_mask` is all zero and `lp_hit` is 0.
- R10: For delivery mode 5 with level (bit 14) = 0 and trigger (bit 15) = 1, `deliver_mask` is zero, `arb_load_mask` holds the matched set, and each matched unit's arbitration ID becomes its physical ID. Other units keep their arbitration IDs. Any other command leaves all arbitration IDs unchanged and drives `arb_load_mask` to zero.
- R11: Outputs are registered: a command accepted with `cmd_valid` at a rising edge shows on the outputs right after that edge, with `out_vector` equal to low word bits 7:0. After an edge with `cmd_valid` low, `out_valid`, `deliver_mask`, `lp_hit` and `arb_load_mask` are zero.
- R12: A synchronous active-low reset clears all outputs and sets every arbitration ID to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_lo | input | 32 | Command low word: vector, delivery mode, logical bit, level, trigger, shorthand |
| cmd_hi | input | 32 | Command high word: destination in bits 31:24 |
| sender_idx | input | 3 (log2 N) | Index of the sending unit |
| unit_phys_id | input | 64 (8·N) | Physical ID of unit i in bits 8i+7:8i |
| unit_log_dest | input | 64 (8·N) | Logical destination of unit i in bits 8i+7:8i |
| unit_model | input | 32 (4·N) | Destination model of unit i in bits 4i+3:4i |
| out_valid | output | 1 | Result of a command is on the outputs |
| out_vector | output | 8 | Vector of that command |
| deliver_mask | output | 8 (N) | Units that receive the interrupt |
| lp_hit | output | 1 | Lowest-priority target is named |
| lp_index | output | 3 (log2 N) | Index of the lowest-priority target |
| arb_load_mask | output | 8 (N) | Units whose arbitration ID was reloaded |
| arb_id_flat | output | 64 (8·N) | Arbitration ID of unit i in bits 8i+7:8i |

## Verification
A wrong per-unit match term would show as one bit of `deliver_mask` set or clear against the computed set. This is visible on the very next output cycle for any destination that reaches that unit, so full sweeps of all 256 destinations in both modes catch it at once. A wrong lowest-index pick shows in `lp_index` or in a mask with more than one bit set. The arbitration ID store is the only lasting state. A wrong load would stay visible on `arb_id_flat` until the next reload, so it is read back after every INIT-style command and again after commands that must not touch it.

// File: rtl/idm_pkg.sv
// Package: shared field positions, codes and the decoded command type for
// the interrupt destination matcher. Assumes 32-bit command words.
package idm_pkg;

    localparam int CMD_W      = 32;
    localparam int FLD_W      = 8;
    localparam int MODEL_W    = 4;
    localparam int VEC_LSB    = 0;
    localparam int MODE_LSB   = 8;
    localparam int LOGIC_BIT  = 11;
    localparam int LEVEL_BIT  = 14;
    localparam int TRIG_BIT   = 15;
    localparam int SH_LSB     = 18;
    localparam int DEST_LSB   = 24;

    typedef enum logic [2:0] {
        DLV_FIXED  = 3'd0,
        DLV_LOWEST = 3'd1,
        DLV_SMI    = 3'd2,
        DLV_RSV    = 3'd3,
        DLV_NMI    = 3'd4,
        DLV_INIT   = 3'd5,
        DLV_START  = 3'd6,
        DLV_EXT    = 3'd7
    } dlv_mode_e;

    typedef enum logic [1:0] {
        SH_FIELD  = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    localparam logic [MODEL_W-1:0] MODEL_FLAT    = 4'hF;
    localparam logic [MODEL_W-1:0] MODEL_CLUSTER = 4'h0;
    localparam logic [FLD_W-1:0]   DEST_BCAST    = 8'hFF;

    typedef struct packed {
        logic [FLD_W-1:0] vector;
        dlv_mode_e        mode;
        logic             logical;
        logic             level;
        logic             trigger;
        shorthand_e       shorthand;
        logic [FLD_W-1:0] dest;
    } cmd_t;

endpackage

// File: rtl/idm_cmd_decode.sv
// Module: splits the two command words into named fields and flags the
// arbitration-reload form of INIT. Purely combinational; assumes the
// field positions defined in idm_pkg.
module idm_cmd_decode
    import idm_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_lo,
    input  logic [CMD_W-1:0] cmd_hi,
    output cmd_t             cmd,
    output logic             is_lowest,
    output logic             is_arb_reload
);

    // Field extraction from the fixed bit positions.
    always_comb begin
        cmd.vector    = cmd_lo[VEC_LSB +: FLD_W];
        cmd.mode      = dlv_mode_e'(cmd_lo[MODE_LSB +: 3]);
        cmd.logical   = cmd_lo[LOGIC_BIT];
        cmd.level     = cmd_lo[LEVEL_BIT];
        cmd.trigger   = cmd_lo[TRIG_BIT];
        cmd.shorthand = shorthand_e'(cmd_lo[SH_LSB +: 2]);
        cmd.dest      = cmd_hi[DEST_LSB +: FLD_W];
    end

    // Mode flags used by the output stage.
    always_comb begin
        is_lowest     = (cmd.mode == DLV_LOWEST);
        is_arb_reload = (cmd.mode == DLV_INIT) && !cmd.level && cmd.trigger;
    end

endmodule

// File: rtl/idm_unit_match.sv
// Module: decides whether one unit is addressed by a command. Handles
// physical, flat-logical and cluster-logical matching and the shorthand
// override. Combinational; UNIT_IDX is this unit's own position.
module idm_unit_match
    import idm_pkg::*;
#(
    parameter int SEL_W    = 3,
    parameter int UNIT_IDX = 0
) (
    input  logic [FLD_W-1:0]   dest,
    input  logic               logical,
    input  shorthand_e         shorthand,
    input  logic [SEL_W-1:0]   sender_idx,
    input  logic [FLD_W-1:0]   phys_id,
    input  logic [FLD_W-1:0]   log_dest,
    input  logic [MODEL_W-1:0] model,
    output logic               hit
);

    localparam int HALF = FLD_W / 2;

    logic is_self;
    logic phys_hit;
    logic flat_hit;
    logic clus_hit;
    logic log_hit;

    // Physical match: broadcast value or exact ID equality.
    always_comb begin
        phys_hit = (dest == DEST_BCAST) || (dest == phys_id);
    end

    // Logical match according to this unit's model.
    always_comb begin
        flat_hit = |(dest & log_dest);
        clus_hit = (dest[FLD_W-1:HALF] == log_dest[FLD_W-1:HALF]) &&
                   (|(dest[HALF-1:0] & log_dest[HALF-1:0]));
        case (model)
            MODEL_FLAT:    log_hit = flat_hit;
            MODEL_CLUSTER: log_hit = clus_hit;
            default:       log_hit = 1'b0;
        endcase
    end

    // Shorthand selects between the field match and fixed sets.
    always_comb begin
        is_self = (sender_idx == SEL_W'(UNIT_IDX));
        case (shorthand)
            SH_SELF:   hit = is_self;
            SH_ALL:    hit = 1'b1;
            SH_OTHERS: hit = !is_self;
            default:   hit = logical ? log_hit : phys_hit;
        endcase
    end

endmodule

// File: rtl/idm_lowest_pick.sv
// Module: finds the lowest-indexed set bit of a mask and returns it as a
// one-hot vector and an index. Combinational; all-zero input gives
// any = 0, onehot = 0, index = 0.
module idm_lowest_pick #(
    parameter int N     = 8,
    parameter int SEL_W = 3
) (
    input  logic [N-1:0]     mask,
    output logic [N-1:0]     onehot,
    output logic [SEL_W-1:0] index,
    output logic             any
);

    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        onehot = '0;
        index  = '0;
        any    = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                onehot    = '0;
                onehot[i] = 1'b1;
                index     = SEL_W'(i);
                any       = 1'b1;
            end
        end
    end

endmodule

// File: rtl/idm_matcher.sv
// Module: top of the interrupt destination matcher. Registers one result
// per accepted command and holds the arbitration ID of each unit.
// Assumes N >= 2 and unit configuration stable while a command is valid.
module idm_matcher
    import idm_pkg::*;
#(
    parameter int N     = 8,
    parameter int SEL_W = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [31:0]          cmd_lo,
    input  logic [31:0]          cmd_hi,
    input  logic [SEL_W-1:0]     sender_idx,
    input  logic [N*8-1:0]       unit_phys_id,
    input  logic [N*8-1:0]       unit_log_dest,
    input  logic [N*4-1:0]       unit_model,
    output logic                 out_valid,
    output logic [7:0]           out_vector,
    output logic [N-1:0]         deliver_mask,
    output logic                 lp_hit,
    output logic [SEL_W-1:0]     lp_index,
    output logic [N-1:0]         arb_load_mask,
    output logic [N*8-1:0]       arb_id_flat
);

    cmd_t             cmd;
    logic             is_lowest;
    logic             is_arb_reload;
    logic [N-1:0]     match;
    logic [N-1:0]     pick_onehot;
    logic [SEL_W-1:0] pick_index;
    logic             pick_any;
    logic [N-1:0]     next_deliver;
    logic [N-1:0]     next_load;

    idm_cmd_decode u_dec (
        .cmd_lo        (cmd_lo),
        .cmd_hi        (cmd_hi),
        .cmd           (cmd),
        .is_lowest     (is_lowest),
        .is_arb_reload (is_arb_reload)
    );

    for (genvar g = 0; g < N; g++) begin : g_unit
        idm_unit_match #(
            .SEL_W    (SEL_W),
            .UNIT_IDX (g)
        ) u_match (
            .dest       (cmd.dest),
            .logical    (cmd.logical),
            .shorthand  (cmd.shorthand),
            .sender_idx (sender_idx),
            .phys_id    (unit_phys_id[g*FLD_W +: FLD_W]),
            .log_dest   (unit_log_dest[g*FLD_W +: FLD_W]),
            .model      (unit_model[g*MODEL_W +: MODEL_W]),
            .hit        (match[g])
        );
    end

    idm_lowest_pick #(
        .N     (N),
        .SEL_W (SEL_W)
    ) u_pick (
        .mask   (match),
        .onehot (pick_onehot),
        .index  (pick_index),
        .any    (pick_any)
    );

    // Choose what reaches the units for this command's delivery mode.
    always_comb begin
        if (is_arb_reload) begin
            next_deliver = '0;
            next_load    = match;
        end else if (is_lowest) begin
            next_deliver = pick_onehot;
            next_load    = '0;
        end else begin
            next_deliver = match;
            next_load    = '0;
        end
    end

    // Result register: one result per accepted command, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_vector    <= '0;
            deliver_mask  <= '0;
            lp_hit        <= 1'b0;
            lp_index      <= '0;
            arb_load_mask <= '0;
        end else if (cmd_valid) begin
            out_valid     <= 1'b1;
            out_vector    <= cmd.vector;
            deliver_mask  <= next_deliver;
            lp_hit        <= is_lowest && pick_any;
            lp_index      <= is_lowest ? pick_index : '0;
            arb_load_mask <= next_load;
        end else begin
            out_valid     <= 1'b0;
            out_vector    <= '0;
            deliver_mask  <= '0;
            lp_hit        <= 1'b0;
            lp_index      <= '0;
            arb_load_mask <= '0;
        end
    end

    for (genvar a = 0; a < N; a++) begin : g_arb
        // Arbitration ID store: reload from the physical ID when selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                arb_id_flat[a*FLD_W +: FLD_W] <= '0;
            end else if (cmd_valid && next_load[a]) begin
                arb_id_flat[a*FLD_W +: FLD_W] <= unit_phys_id[a*FLD_W +: FLD_W];
            end
        end
    end

endmodule

// File: rtl/idm_matcher_chk.sv
// Module: assertion checker for idm_matcher, attached by bind below.
// Observes only the top-level ports.
module idm_matcher_chk #(
    parameter int N     = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_valid,
    input  logic [N-1:0]     deliver_mask,
    input  logic             lp_hit,
    input  logic [SEL_W-1:0] lp_index,
    input  logic [N-1:0]     arb_load_mask,
    input  logic [N*8-1:0]   arb_id_flat
);

    // R12: reset leaves the outputs and arbitration IDs cleared.
    assert_reset_clear_R12: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && deliver_mask == '0 && arb_id_flat == '0));

    // R8: a named lowest-priority target is the single delivered unit.
    assert_lowest_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lp_hit |-> ($countones(deliver_mask) == 1 && deliver_mask[lp_index]));

    // R9: an empty result never names a target.
    assert_empty_no_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_mask == '0) |-> !lp_hit);

    // R10: a reload command delivers nothing.
    assert_reload_no_delivery_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_load_mask != '0) |-> (deliver_mask == '0 && !lp_hit));

    // R10: arbitration IDs only change on a reload.
    assert_arb_change_only_on_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(arb_id_flat) |-> (arb_load_mask != '0));

    // R11: with no result presented, every result output is quiet.
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (deliver_mask == '0 && !lp_hit && arb_load_mask == '0));

endmodule

bind idm_matcher idm_matcher_chk #(
    .N     (N),
    .SEL_W (SEL_W)
) u_idm_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .out_valid     (out_valid),
    .deliver_mask  (deliver_mask),
    .lp_hit        (lp_hit),
    .lp_index      (lp_index),
    .arb_load_mask (arb_load_mask),
    .arb_id_flat   (arb_id_flat)
);

// File: tb/idm_matcher_test.sv
// Bench: sweeps every destination in both modes plus all shorthands and
// senders; expected sets are computed from the requirements.
module idm_matcher_test;

    localparam int N = 8;
    localparam int S = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_valid = 1'b0;
    logic [31:0]    cmd_lo = '0;
    logic [31:0]    cmd_hi = '0;
    logic [S-1:0]   sender_idx = '0;
    logic [N*8-1:0] unit_phys_id = '0;
    logic [N*8-1:0] unit_log_dest = '0;
    logic [N*4-1:0] unit_model = '0;
    logic           out_valid;
    logic [7:0]     out_vector;
    logic [N-1:0]   deliver_mask;
    logic           lp_hit;
    logic [S-1:0]   lp_index;
    logic [N-1:0]   arb_load_mask;
    logic [N*8-1:0] arb_id_flat;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] ids  [N] = '{8'h03, 8'h11, 8'h28, 8'h55, 8'h80, 8'h9A, 8'hC3, 8'hFE};
    logic [7:0] ldst [N] = '{8'h01, 8'h06, 8'h10, 8'hC0, 8'h21, 8'h32, 8'h24, 8'hFF};
    logic [3:0] mdl  [N] = '{4'hF, 4'hF, 4'hF, 4'hF, 4'h0, 4'h0, 4'h0, 4'h5};
    logic [7:0] exp_arb [N];

    always #10 clk = ~clk;

    idm_matcher #(.N(N)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_lo(cmd_lo),
        .cmd_hi(cmd_hi), .sender_idx(sender_idx), .unit_phys_id(unit_phys_id),
        .unit_log_dest(unit_log_dest), .unit_model(unit_model),
        .out_valid(out_valid), .out_vector(out_vector),
        .deliver_mask(deliver_mask), .lp_hit(lp_hit), .lp_index(lp_index),
        .arb_load_mask(arb_load_mask), .arb_id_flat(arb_id_flat)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    function automatic logic [31:0] mk_lo(input int vec, input int mode, input bit lg,
                                          input bit lvl, input bit trg, input int sh);
        return 32'(vec & 255) | (32'(mode & 7) << 8) | (32'(lg) << 11) |
               (32'(lvl) << 14) | (32'(trg) << 15) | (32'(sh & 3) << 18);
    endfunction

    // Matched set from R1 to R7.
    function automatic logic [N-1:0] exp_match(input logic [31:0] lo, input logic [31:0] hi,
                                                 input int snd);
        logic [N-1:0] m = '0;
        int d = int'(hi[31:24]);
        int sh = int'(lo[19:18]);
        for (int u = 0; u < N; u++) begin
            int ld = int'(ldst[u]);
            bit h;
            if (sh == 1) h = (u == snd);
            else if (sh == 2) h = 1'b1;
            else if (sh == 3) h = (u != snd);
            else if (!lo[11]) h = (d == 255) || (d == int'(ids[u]));
            else if (mdl[u] == 4'hF) h = ((d & ld) != 0);
            else if (mdl[u] == 4'h0) h = ((d / 16) == (ld / 16)) && (((d % 16) & (ld % 16)) != 0);
            else h = 1'b0;
            m[u] = h;
        end
        return m;
    endfunction

    // Issue one command and compare every result output.
    task automatic issue(input string req, input logic [31:0] lo, input logic [31:0] hi,
                         input int snd);
        logic [N-1:0] m;
        logic [N-1:0] dm;
        logic [N-1:0] ld;
        logic hit;
        logic [S-1:0] idx;
        int mode;
        bit reload;
        m = exp_match(lo, hi, snd);
        mode = int'(lo[10:8]);
        reload = (mode == 5) && !lo[14] && lo[15];
        hit = 1'b0;
        idx = '0;
        ld = '0;
        if (reload) begin
            dm = '0;
            ld = m;
        end else if (mode == 1) begin
            dm = m & (~m + 1'b1);
            hit = (m != '0);
            for (int u = N - 1; u >= 0; u--) if (m[u]) idx = S'(u);
        end else begin
            dm = m;
        end
        @(negedge clk);
        cmd_lo = lo;
        cmd_hi = hi;
        sender_idx = S'(snd);
        cmd_valid = 1'b1;
        @(posedge clk);
        #1;
        chk(req, {out_valid, out_vector, deliver_mask, lp_hit, lp_index, arb_load_mask},
                 {1'b1, lo[7:0], dm, hit, idx, ld});
        for (int u = 0; u < N; u++) if (ld[u]) exp_arb[u] = ids[u];
        chk({req, " arbitration"}, arb_id_flat,
            {exp_arb[7], exp_arb[6], exp_arb[5], exp_arb[4],
             exp_arb[3], exp_arb[2], exp_arb[1], exp_arb[0]});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : main
        for (int u = 0; u < N; u++) begin
            unit_phys_id[u*8 +: 8]  = ids[u];
            unit_log_dest[u*8 +: 8] = ldst[u];
            unit_model[u*4 +: 4]    = mdl[u];
            exp_arb[u] = 8'h00;
        end
        repeat (4) @(posedge clk);
        #1;
        // R12: cleared after reset
        chk("R12 reset", {out_valid, deliver_mask, lp_hit, arb_load_mask, arb_id_flat},
                         '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 physical sweep, fixed and lowest-priority (R8 R9)
        for (int d = 0; d < 256; d++) begin
            issue(d == 255 ? "R1 physical" : "R2 physical",
                  mk_lo(d, 0, 0, 0, 0, 0), 32'(d) << 24, 0);
            issue("R8 R9 physical lowest", mk_lo(d ^ 8'h5A, 1, 0, 0, 0, 0), 32'(d) << 24, 0);
        end
        // R3 R4 R5 logical sweep, fixed and lowest-priority
        for (int d = 0; d < 256; d++) begin
            issue("R3 R4 R5 logical", mk_lo(d, 0, 1, 0, 0, 0), 32'(d) << 24, 0);
            issue("R8 logical lowest", mk_lo(d, 1, 1, 0, 0, 0), 32'(d) << 24, 0);
        end
        // R5: unit 7 has a model matching no logical destination
        issue("R5 odd model", mk_lo(8'h40, 0, 1, 0, 0, 0), 32'hFF00_0000, 0);
        chk("R5 unit7 bit", deliver_mask[7], 1'b0);
        // R9: nobody matches
        issue("R9 none", mk_lo(8'h41, 1, 0, 0, 0, 0), 32'h7700_0000, 2);
        chk("R9 empty", {deliver_mask, lp_hit}, '0);
        // R6 R7 shorthands for every sender
        for (int s = 0; s < N; s++) begin
            issue("R6 self", mk_lo(8'h30, 0, 0, 0, 0, 1), 32'h7700_0000, s);
            issue("R7 all", mk_lo(8'h31, 0, 1, 0, 0, 2), 32'h0000_0000, s);
            issue("R7 others", mk_lo(8'h32, 0, 0, 0, 0, 3), 32'hFF00_0000, s);
            issue("R8 R6 self lowest", mk_lo(8'h33, 1, 0, 0, 0, 1), 32'h0300_0000, s);
        end
        // R10: reload to a logical group, then normal INIT and other forms
        issue("R10 reload flat", mk_lo(8'h00, 5, 1, 0, 1, 0), 32'h1600_0000, 0);
        issue("R10 init level", mk_lo(8'h00, 5, 1, 1, 1, 0), 32'hFF00_0000, 0);
        issue("R10 init edge", mk_lo(8'h00, 5, 0, 0, 0, 0), 32'hFF00_0000, 0);
        issue("R10 reload others", mk_lo(8'h00, 5, 0, 0, 1, 3), 32'h0000_0000, 6);
        issue("R10 reload phys", mk_lo(8'h00, 5, 0, 0, 1, 0), 32'hC300_0000, 0);
        // R11: idle cycle quiets the outputs
        @(negedge clk);
        cmd_valid = 1'b0;
        @(posedge clk);
        #1;
        chk("R11 idle", {out_valid, out_vector, deliver_mask, lp_hit, arb_load_mask}, '0);
        issue("R11 vector", mk_lo(8'hE7, 4, 0, 0, 0, 2), 32'h0, 0);
        finish_run();
    end

endmodule